// File: doc/BRIEF.md
# Four-Channel DMA Base Register Port

This block is the programming front end of a four-channel DMA controller. Each channel holds a 16-bit start address and a 16-bit transfer count. Software reaches all eight of these words through a single 8-bit data port, picking one of eight consecutive register selects. Because each word is twice the port width, one shared byte pointer decides whether an access lands on the low or the high half.

The pointer flips on every access, whether a read or a write, and whichever register the access targets. A driver that interleaves accesses to different registers therefore sees the halves alternate across them. Three single-cycle command strobes reset the machine state:
- a pointer clear;
- a mask clear, which drops all four channel mask bits;
- a master clear, which clears the pointer and raises every mask bit.

A synchronous reset acts like a master clear and also zeroes the stored words. The transfer engine, arbitration, mode and status registers are not part of this block.

Top module: `dma_basereg_port`

## Requirements
- R1: While `rst` is high at a clock edge, all eight stored words become 0x0000, the byte pointer selects the low half, and `mask_bits` becomes 4'b1111.
- R2: `reg_sel[2:1]` names the channel (0 to 3) and `reg_sel[0]` picks the word within it: 0 is the address word and 1 is the count word.
- R3: After a pointer clear, the first access reaches bits 7:0 of the selected word and the second reaches bits 15:8. Later accesses keep alternating.
- R4: A single pointer serves all channels and both access kinds. Each clock edge with `wr_stb` or `rd_stb` high toggles it exactly once, whatever `reg_sel` selects. Edges with neither strobe high leave it unchanged.
- R5: `rd_data` combinationally shows the half of the selected word that the pointer currently chooses. A read never alters any stored word.
- R6: At an edge with `clr_ptr_stb` high, the pointer goes to the low half even if an access occurs at that same edge. Such an access still uses the half that the pointer chose before the edge.
- R7: At an edge with `master_clr_stb` high, the pointer clears and `mask_bits` becomes 4'b1111. The stored words keep their values.
- R8: At an edge with `mask_clr_stb` high and `master_clr_stb` low, `mask_bits` becomes 4'b0000; if both are high, the master clear wins. The mask clear does not affect the pointer. At edges with neither strobe, `mask_bits` holds its value.
- R9: A write changes only the one addressed byte. All other bytes of all eight words are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_sel | input | 3 | Register select: channel in bits 2:1, count/address in bit 0 |
| wr_stb | input | 1 | Write strobe, one access per high cycle |
| rd_stb | input | 1 | Read strobe, one access per high cycle |
| wr_data | input | 8 | Byte to write |
| rd_data | output | 8 | Selected byte of the selected word |
| clr_ptr_stb | input | 1 | Pointer clear command |
| mask_clr_stb | input | 1 | Clear all channel mask bits |
| master_clr_stb | input | 1 | Master clear: pointer clear, all mask bits set |
| mask_bits | output | 4 | Channel mask bits, one per channel |

## Verification
A pointer in the wrong state shows up at the very next read. That read returns the other half of the selected word, and every read after it stays swapped until a clear, so interleaved reads across registers expose it within one access. A corrupted or wrongly decoded word appears the first time that word is read back, as a wrong byte in `rd_data`. A mask command that misbehaves shows on `mask_bits` one cycle after the strobe.

// File: rtl/dma_basereg_pkg.sv
package dma_basereg_pkg;

  typedef enum logic {
    HALF_LO = 1'b0,
    HALF_HI = 1'b1
  } half_e;

  // A clear command has priority over the toggle of an access.
  function automatic half_e next_half(half_e cur, logic access, logic clear);
    if (clear)
      return HALF_LO;
    if (access)
      return (cur == HALF_LO) ? HALF_HI : HALF_LO;
    return cur;
  endfunction

endpackage

// File: rtl/dma_byte_ptr.sv
module dma_byte_ptr
  import dma_basereg_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  access,
  input  logic  clear,
  output half_e half_q
);

  always_ff @(posedge clk) begin
    if (rst)
      half_q <= HALF_LO;
    else
      half_q <= next_half(half_q, access, clear);
  end

endmodule

// File: rtl/dma_chan_pair.sv
module dma_chan_pair
  import dma_basereg_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_addr,
  input  logic                  wr_cnt,
  input  half_e                 half,
  input  logic [DATA_W-1:0]     wdata,
  output logic [2*DATA_W-1:0]   addr_q,
  output logic [2*DATA_W-1:0]   cnt_q
);

  localparam int WORD_W = 2 * DATA_W;

  function automatic logic [WORD_W-1:0] merge_byte(logic [WORD_W-1:0] old,
                                                   half_e h,
                                                   logic [DATA_W-1:0] b);
    logic [WORD_W-1:0] r;
    r = old;
    if (h == HALF_HI)
      r[WORD_W-1:DATA_W] = b;
    else
      r[DATA_W-1:0] = b;
    return r;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (wr_addr)
        addr_q <= merge_byte(addr_q, half, wdata);
      if (wr_cnt)
        cnt_q <= merge_byte(cnt_q, half, wdata);
    end
  end

endmodule

// File: rtl/dma_mask_reg.sv
module dma_mask_reg #(
  parameter int CH_COUNT = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                mask_clr,
  input  logic                master_clr,
  output logic [CH_COUNT-1:0] mask_q
);

  always_ff @(posedge clk) begin
    if (rst || master_clr)
      mask_q <= '1;
    else if (mask_clr)
      mask_q <= '0;
  end

endmodule

// File: rtl/dma_basereg_port.sv
module dma_basereg_port
  import dma_basereg_pkg::*;
#(
  parameter int CH_COUNT = 4,
  parameter int DATA_W   = 8
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [$clog2(CH_COUNT):0]     reg_sel,
  input  logic                          wr_stb,
  input  logic                          rd_stb,
  input  logic [DATA_W-1:0]             wr_data,
  output logic [DATA_W-1:0]             rd_data,
  input  logic                          clr_ptr_stb,
  input  logic                          mask_clr_stb,
  input  logic                          master_clr_stb,
  output logic [CH_COUNT-1:0]           mask_bits
);

  localparam int CH_W   = $clog2(CH_COUNT);
  localparam int SEL_W  = CH_W + 1;
  localparam int WORD_W = 2 * DATA_W;

  function automatic logic [CH_W-1:0] sel_chan(logic [SEL_W-1:0] s);
    return s[SEL_W-1:1];
  endfunction

  function automatic logic sel_is_cnt(logic [SEL_W-1:0] s);
    return s[0];
  endfunction

  function automatic logic [DATA_W-1:0] pick_byte(logic [WORD_W-1:0] w, half_e h);
    return (h == HALF_HI) ? w[WORD_W-1:DATA_W] : w[DATA_W-1:0];
  endfunction

  // Named internal events, visible to the bound checker.
  logic  access_evt;
  logic  ptr_clear_evt;
  logic  ptr_hi;
  half_e half_q;

  assign access_evt    = wr_stb | rd_stb;
  assign ptr_clear_evt = clr_ptr_stb | master_clr_stb;
  assign ptr_hi        = (half_q == HALF_HI);

  dma_byte_ptr u_ptr (
    .clk    (clk),
    .rst    (rst),
    .access (access_evt),
    .clear  (ptr_clear_evt),
    .half_q (half_q)
  );

  dma_mask_reg #(.CH_COUNT(CH_COUNT)) u_mask (
    .clk        (clk),
    .rst        (rst),
    .mask_clr   (mask_clr_stb),
    .master_clr (master_clr_stb),
    .mask_q     (mask_bits)
  );

  logic [WORD_W-1:0] addr_words [CH_COUNT];
  logic [WORD_W-1:0] cnt_words  [CH_COUNT];

  for (genvar g = 0; g < CH_COUNT; g++) begin : g_chan
    logic hit;
    assign hit = wr_stb && (sel_chan(reg_sel) == CH_W'(g));

    dma_chan_pair #(.DATA_W(DATA_W)) u_pair (
      .clk     (clk),
      .rst     (rst),
      .wr_addr (hit && !sel_is_cnt(reg_sel)),
      .wr_cnt  (hit &&  sel_is_cnt(reg_sel)),
      .half    (half_q),
      .wdata   (wr_data),
      .addr_q  (addr_words[g]),
      .cnt_q   (cnt_words[g])
    );
  end

  logic [WORD_W-1:0] sel_word;

  always_comb begin
    if (sel_is_cnt(reg_sel))
      sel_word = cnt_words[sel_chan(reg_sel)];
    else
      sel_word = addr_words[sel_chan(reg_sel)];
    rd_data = pick_byte(sel_word, half_q);
  end

endmodule

// File: rtl/dma_basereg_chk.sv
module dma_basereg_chk #(
  parameter int CH_COUNT = 4
) (
  input logic                clk,
  input logic                rst,
  input logic                wr_stb,
  input logic                rd_stb,
  input logic                clr_ptr_stb,
  input logic                mask_clr_stb,
  input logic                master_clr_stb,
  input logic [CH_COUNT-1:0] mask_bits,
  input logic                ptr_hi
);

  a_r6_clear_wins: assert property (@(posedge clk) disable iff (rst)
    (clr_ptr_stb || master_clr_stb) |=> !ptr_hi);

  a_r4_access_toggles: assert property (@(posedge clk) disable iff (rst)
    ((wr_stb || rd_stb) && !clr_ptr_stb && !master_clr_stb) |=> (ptr_hi != $past(ptr_hi)));

  a_r4_idle_holds: assert property (@(posedge clk) disable iff (rst)
    (!wr_stb && !rd_stb && !clr_ptr_stb && !master_clr_stb) |=> $stable(ptr_hi));

  a_r7_master_sets_mask: assert property (@(posedge clk) disable iff (rst)
    master_clr_stb |=> (mask_bits == '1));

  a_r8_mask_clear: assert property (@(posedge clk) disable iff (rst)
    (mask_clr_stb && !master_clr_stb) |=> (mask_bits == '0));

  a_r8_mask_holds: assert property (@(posedge clk) disable iff (rst)
    (!mask_clr_stb && !master_clr_stb) |=> $stable(mask_bits));

endmodule

bind dma_basereg_port dma_basereg_chk #(.CH_COUNT(CH_COUNT)) u_chk (
  .clk            (clk),
  .rst            (rst),
  .wr_stb         (wr_stb),
  .rd_stb         (rd_stb),
  .clr_ptr_stb    (clr_ptr_stb),
  .mask_clr_stb   (mask_clr_stb),
  .master_clr_stb (master_clr_stb),
  .mask_bits      (mask_bits),
  .ptr_hi         (ptr_hi)
);

// File: tb/dma_basereg_port_test.sv
`timescale 1ns/1ps
module dma_basereg_port_test;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] reg_sel = '0;
  logic       wr_stb = 1'b0, rd_stb = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic       clr_ptr_stb = 1'b0, mask_clr_stb = 1'b0, master_clr_stb = 1'b0;
  logic [3:0] mask_bits;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  // Bench model, built from the requirements.
  logic [15:0] m_reg [8];
  logic        m_ptr;
  logic [3:0]  m_mask;

  logic [7:0] exp_q [$];
  string      tag_q [$];

  always #5 clk = ~clk;

  dma_basereg_port uut (
    .clk(clk), .rst(rst), .reg_sel(reg_sel), .wr_stb(wr_stb), .rd_stb(rd_stb),
    .wr_data(wr_data), .rd_data(rd_data), .clr_ptr_stb(clr_ptr_stb),
    .mask_clr_stb(mask_clr_stb), .master_clr_stb(master_clr_stb),
    .mask_bits(mask_bits)
  );

  // Monitor: compares each read byte mid-cycle against the scoreboard.
  always @(negedge clk) begin
    if (!rst && rd_stb) begin
      checks++;
      if (exp_q.size() == 0) begin
        failures++;
        $display("FAIL scoreboard underflow: read got %02h, expected none", rd_data);
      end else begin
        automatic logic [7:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        if (rd_data !== e) begin
          failures++;
          $display("FAIL %s sel=%0d: rd_data=%02h expected %02h", t, reg_sel, rd_data, e);
        end
      end
    end
  end

  task automatic model_reset();
    for (int i = 0; i < 8; i++) m_reg[i] = 16'h0000;
    m_ptr = 1'b0;
    m_mask = 4'hF;
  endtask

  task automatic step(input logic w, input logic r, input logic [2:0] s,
                      input logic [7:0] d, input logic c, input logic mc,
                      input logic ms, input string tag);
    @(posedge clk); #1;
    wr_stb = w; rd_stb = r; reg_sel = s; wr_data = d;
    clr_ptr_stb = c; mask_clr_stb = mc; master_clr_stb = ms;
    if (r) begin
      exp_q.push_back(m_ptr ? m_reg[s][15:8] : m_reg[s][7:0]);
      tag_q.push_back(tag);
    end
    if (w) begin
      if (m_ptr) m_reg[s][15:8] = d;
      else       m_reg[s][7:0]  = d;
    end
    if (w || r) m_ptr = ~m_ptr;
    if (c || ms) m_ptr = 1'b0;
    if (ms) m_mask = 4'hF;
    else if (mc) m_mask = 4'h0;
  endtask

  task automatic idle();
    step(1'b0, 1'b0, 3'd0, 8'h00, 1'b0, 1'b0, 1'b0, "");
  endtask

  task automatic rd(input logic [2:0] s, input string tag);
    step(1'b0, 1'b1, s, 8'h00, 1'b0, 1'b0, 1'b0, tag);
  endtask

  task automatic wr(input logic [2:0] s, input logic [7:0] d, input string tag);
    step(1'b1, 1'b0, s, d, 1'b0, 1'b0, 1'b0, tag);
  endtask

  task automatic check_mask(input string tag);
    checks++;
    if (mask_bits !== m_mask) begin
      failures++;
      $display("FAIL %s: mask_bits=%b expected %b", tag, mask_bits, m_mask);
    end
  endtask

  task automatic read_all(input string tag);
    for (int i = 0; i < 8; i++) begin
      rd(3'(i), tag);
      rd(3'(i), tag);
    end
  endtask

  task automatic do_reset();
    @(posedge clk); #1;
    rst = 1'b1;
    wr_stb = 0; rd_stb = 0; clr_ptr_stb = 0; mask_clr_stb = 0; master_clr_stb = 0;
    repeat (2) @(posedge clk);
    #1 rst = 1'b0;
    model_reset();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: run did not end, expected completion");
    finish_run();
  end

  initial begin
    model_reset();
    do_reset();

    // R1: reset state
    check_mask("R1");
    read_all("R1");

    // R2 / R3: fill all eight words low then high, read back
    rd(3'd0, "R3");
    step(1'b0, 1'b0, 3'd0, 8'h00, 1'b1, 1'b0, 1'b0, "R3");
    for (int i = 0; i < 8; i++) begin
      wr(3'(i), 8'h10 + 8'(i), "R3");
      wr(3'(i), 8'hA0 + 8'(i), "R3");
    end
    read_all("R2");

    // R4: interleaved access to different words shares the pointer
    wr(3'd1, 8'hC3, "R4");
    rd(3'd2, "R4");
    wr(3'd1, 8'h3C, "R4");
    rd(3'd5, "R4");
    rd(3'd1, "R4");
    rd(3'd1, "R4");

    // R6: clear alone, then clear together with a write
    rd(3'd0, "R6");
    step(1'b0, 1'b0, 3'd0, 8'h00, 1'b1, 1'b0, 1'b0, "R6");
    rd(3'd0, "R6");
    rd(3'd3, "R6");
    step(1'b1, 1'b0, 3'd4, 8'hEE, 1'b1, 1'b0, 1'b0, "R6");
    rd(3'd4, "R6");
    rd(3'd4, "R6");

    // R8: mask clear, and no pointer effect with a concurrent read
    step(1'b0, 1'b0, 3'd0, 8'h00, 1'b0, 1'b1, 1'b0, "R8");
    idle();
    check_mask("R8");
    step(1'b0, 1'b1, 3'd5, 8'h00, 1'b0, 1'b1, 1'b0, "R8");
    rd(3'd5, "R8");

    // R7: master clear sets mask, clears pointer, keeps words
    rd(3'd6, "R7");
    step(1'b0, 1'b0, 3'd0, 8'h00, 1'b0, 1'b0, 1'b1, "R7");
    idle();
    check_mask("R7");
    rd(3'd6, "R7");
    rd(3'd6, "R7");

    // R8: master wins over mask clear
    step(1'b0, 1'b0, 3'd0, 8'h00, 1'b0, 1'b1, 1'b1, "R8");
    idle();
    check_mask("R8");
    step(1'b0, 1'b0, 3'd0, 8'h00, 1'b0, 1'b1, 1'b0, "R8");
    idle();
    check_mask("R8");
    idle();
    check_mask("R8");

    // R9: single byte write leaves everything else intact
    wr(3'd7, 8'h5A, "R9");
    step(1'b0, 1'b0, 3'd0, 8'h00, 1'b1, 1'b0, 1'b0, "R9");
    read_all("R9");

    // R5: reads alone never alter contents
    read_all("R5");
    read_all("R5");

    // R1: reset mid-run zeroes words and raises mask
    do_reset();
    check_mask("R1");
    read_all("R1");

    idle();
    idle();
    checks++;
    if (exp_q.size() != 0) begin
      failures++;
      $display("FAIL scoreboard: %0d reads pending, expected 0", exp_q.size());
    end
    finish_run();
  end

endmodule